// File: doc/BRIEF.md
# Time Alarm and Interrupt Flag Unit

This block sits beside a clock/calendar counter. It decides when a daily time alarm is due and gathers every interrupt source of the clock into one status byte and one interrupt line. Once per second the counter pulses an update-done strobe. On that pulse the block compares the current hours, minutes and seconds bytes with three alarm bytes. An alarm byte whose two top bits are both set is a wildcard, so an alarm can fire every hour, every minute or every second.

There are six event flags: periodic, alarm, update-ended, wake-up, kickstart and RAM-clear. Each flag is set by its own event whether or not its enable is on. The enables gate only the summary flag and the active-low interrupt output. A read strobe on the status byte clears the periodic, alarm and update-ended flags. The other three flags are cleared by per-flag clear strobes from the register that holds them.

Top module: `alm_irq_unit`

## Requirements
- R1: After a synchronous reset, `stat_byte` is 00h, `ext_flags` is 000 and `irq_n` is 1.
- R2: An `upd_done` pulse sets the update-ended flag, seen as `stat_byte` bit 4 after that clock edge, whatever the enables are.
- R3: The alarm flag (`stat_byte` bit 5) is set only on an `upd_done` pulse during which all three alarm bytes match the current time. A match with no `upd_done` pulse leaves the flag clear.
- R4: An alarm byte in the range C0h to FFh (bits 7:6 both 1) matches any value of its field. A value such as BFh is compared as an exact value.
- R5: If any non-wildcard alarm byte differs from its time field, the `upd_done` pulse sets the update-ended flag but not the alarm flag.
- R6: A `per_tick` pulse sets the periodic flag, seen as `stat_byte` bit 6.
- R7: `stat_byte` bit 7 is the OR of the six flag-and-enable pairs. Flags set with their enable off leave bit 7 at 0.
- R8: `irq_n` is 0 exactly when `stat_byte` bit 7 is 1. Both change on the same edge.
- R9: A `stat_rd` pulse clears bits 6, 5 and 4 at the clock edge where it is sampled. An event that arrives on that same edge sets its flag anyway.
- R10: `wake_evt`, `kick_evt` and `ramclr_evt` set `ext_flags` bits 0, 1 and 2 respectively. The matching bit of `ext_clr` clears each one, and a set on the same edge as a clear wins.
- R11: The summary stays 1 until every enabled flag that is set has been cleared. Clearing only some of them keeps `irq_n` low.
- R12: `stat_byte` bits 3:0 always read 0. A change of an enable takes effect on the summary at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_sec | input | DATA_W | Current seconds byte |
| cur_min | input | DATA_W | Current minutes byte |
| cur_hr | input | DATA_W | Current hours byte |
| alm_sec | input | DATA_W | Seconds alarm byte |
| alm_min | input | DATA_W | Minutes alarm byte |
| alm_hr | input | DATA_W | Hours alarm byte |
| upd_done | input | 1 | Once-per-second update finished strobe |
| per_tick | input | 1 | Periodic interrupt tick |
| wake_evt | input | 1 | Wake-up event strobe |
| kick_evt | input | 1 | Kickstart event strobe |
| ramclr_evt | input | 1 | RAM-clear event strobe |
| ext_clr | input | 3 | Clear strobes for wake, kick, RAM-clear flags |
| en_per | input | 1 | Periodic interrupt enable |
| en_alm | input | 1 | Alarm interrupt enable |
| en_upd | input | 1 | Update-ended interrupt enable |
| en_wake | input | 1 | Wake-up interrupt enable |
| en_kick | input | 1 | Kickstart interrupt enable |
| en_ramclr | input | 1 | RAM-clear interrupt enable |
| stat_rd | input | 1 | Status byte read strobe |
| stat_byte | output | 8 | {summary, PF, AF, UF, 0000} |
| ext_flags | output | 3 | {RAM-clear, kick, wake} flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with the default byte width DATA_W = 8. At that width the wildcard range C0h to FFh and the exact non-wildcard value BFh can both be written as plain hex constants. This also lets every status byte be checked as one whole byte, including the zero low nibble. Since every flag, enable and strobe is a separate port, each of the six summary pairs can be driven alone or overlapped with another. The same holds for the edges where a set and a clear coincide.

// File: rtl/alm_irq_pkg.sv
package alm_irq_pkg;
  localparam int NUM_FIELDS = 3;
  localparam int NUM_FLAGS  = 6;
  localparam int STAT_W     = 8;
  localparam int EXT_W      = 3;

  // flag vector positions
  localparam int FLG_PER  = 0;
  localparam int FLG_ALM  = 1;
  localparam int FLG_UPD  = 2;
  localparam int FLG_WAKE = 3;
  localparam int FLG_KICK = 4;
  localparam int FLG_RCLR = 5;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] cur_val,
  input  logic [DATA_W-1:0] alm_val,
  output logic              hit
);
  localparam int TOP = DATA_W - 1;

  logic wild;

  // both top bits high: the byte matches anything
  always_comb begin
    wild = alm_val[TOP] & alm_val[TOP-1];
    hit  = wild | (cur_val == alm_val);
  end
endmodule

// File: rtl/alm_matcher.sv
module alm_matcher #(
  parameter int DATA_W     = 8,
  parameter int NUM_FIELDS = 3
) (
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] cur_vec,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alm_vec,
  output logic                              all_hit
);
  logic [NUM_FIELDS-1:0] hits;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    alm_field_cmp #(.DATA_W(DATA_W)) u_cmp (
      .cur_val (cur_vec[g]),
      .alm_val (alm_vec[g]),
      .hit     (hits[g])
    );
  end

  assign all_hit = &hits;
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int NUM_FLAGS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set_vec,
  input  logic [NUM_FLAGS-1:0] clr_vec,
  output logic [NUM_FLAGS-1:0] flags_d,
  output logic [NUM_FLAGS-1:0] flags_q
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    // a new event wins over a clear on the same edge
    always_comb flags_d[g] = set_vec[g] | (flags_q[g] & ~clr_vec[g]);

    always_ff @(posedge clk) begin
      if (rst) flags_q[g] <= 1'b0;
      else     flags_q[g] <= flags_d[g];
    end
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int NUM_FLAGS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] flags_d,
  input  logic [NUM_FLAGS-1:0] enables,
  output logic                 sum_q,
  output logic                 irq_n_q
);
  logic sum_d;

  always_comb sum_d = |(flags_d & enables);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      sum_q   <= sum_d;
      irq_n_q <= ~sum_d;
    end
  end
endmodule

// File: rtl/alm_irq_unit.sv
module alm_irq_unit
  import alm_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cur_sec,
  input  logic [DATA_W-1:0] cur_min,
  input  logic [DATA_W-1:0] cur_hr,
  input  logic [DATA_W-1:0] alm_sec,
  input  logic [DATA_W-1:0] alm_min,
  input  logic [DATA_W-1:0] alm_hr,
  input  logic              upd_done,
  input  logic              per_tick,
  input  logic              wake_evt,
  input  logic              kick_evt,
  input  logic              ramclr_evt,
  input  logic [2:0]        ext_clr,
  input  logic              en_per,
  input  logic              en_alm,
  input  logic              en_upd,
  input  logic              en_wake,
  input  logic              en_kick,
  input  logic              en_ramclr,
  input  logic              stat_rd,
  output logic [7:0]        stat_byte,
  output logic [2:0]        ext_flags,
  output logic              irq_n
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] cur_vec, alm_vec;
  logic                              alm_hit;
  logic [NUM_FLAGS-1:0]              set_vec, clr_vec, en_vec;
  logic [NUM_FLAGS-1:0]              flags_d, flags_q;
  logic                              sum_q;

  assign cur_vec = {cur_hr, cur_min, cur_sec};
  assign alm_vec = {alm_hr, alm_min, alm_sec};

  alm_matcher #(.DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS)) u_match (
    .cur_vec (cur_vec),
    .alm_vec (alm_vec),
    .all_hit (alm_hit)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_PER]  = per_tick;
    set_vec[FLG_ALM]  = upd_done & alm_hit;
    set_vec[FLG_UPD]  = upd_done;
    set_vec[FLG_WAKE] = wake_evt;
    set_vec[FLG_KICK] = kick_evt;
    set_vec[FLG_RCLR] = ramclr_evt;

    clr_vec           = '0;
    clr_vec[FLG_PER]  = stat_rd;
    clr_vec[FLG_ALM]  = stat_rd;
    clr_vec[FLG_UPD]  = stat_rd;
    clr_vec[FLG_WAKE] = ext_clr[0];
    clr_vec[FLG_KICK] = ext_clr[1];
    clr_vec[FLG_RCLR] = ext_clr[2];

    en_vec            = '0;
    en_vec[FLG_PER]   = en_per;
    en_vec[FLG_ALM]   = en_alm;
    en_vec[FLG_UPD]   = en_upd;
    en_vec[FLG_WAKE]  = en_wake;
    en_vec[FLG_KICK]  = en_kick;
    en_vec[FLG_RCLR]  = en_ramclr;
  end

  flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_d (flags_d),
    .flags_q (flags_q)
  );

  irq_summary #(.NUM_FLAGS(NUM_FLAGS)) u_sum (
    .clk     (clk),
    .rst     (rst),
    .flags_d (flags_d),
    .enables (en_vec),
    .sum_q   (sum_q),
    .irq_n_q (irq_n)
  );

  assign stat_byte = {sum_q, flags_q[FLG_PER], flags_q[FLG_ALM],
                      flags_q[FLG_UPD], 4'b0000};
  assign ext_flags = {flags_q[FLG_RCLR], flags_q[FLG_KICK], flags_q[FLG_WAKE]};
endmodule

// File: rtl/alm_irq_unit_chk.sv
module alm_irq_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       upd_done,
  input logic       per_tick,
  input logic       stat_rd,
  input logic       all_wild,
  input logic [7:0] stat_byte,
  input logic [2:0] ext_flags,
  input logic       irq_n
);
  AST_UF_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> stat_byte[4]); // R2

  AST_AF_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_byte[5]) |-> $past(upd_done)); // R3

  AST_WILD_ALWAYS_FIRES: assert property (@(posedge clk) disable iff (rst)
    (upd_done && all_wild) |=> stat_byte[5]); // R4

  AST_PF_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    per_tick |=> stat_byte[6]); // R6

  AST_SUM_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    stat_byte[7] |-> ((stat_byte[6:4] != 3'b000) || (ext_flags != 3'b000))); // R7

  AST_IRQ_TRACKS_SUM: assert property (@(posedge clk) disable iff (rst)
    irq_n != stat_byte[7]); // R8

  AST_READ_CLEARS_UF: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !upd_done) |=> !stat_byte[4]); // R9
endmodule

bind alm_irq_unit alm_irq_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .upd_done  (upd_done),
  .per_tick  (per_tick),
  .stat_rd   (stat_rd),
  .all_wild  ((&alm_hr[7:6]) && (&alm_min[7:6]) && (&alm_sec[7:6])),
  .stat_byte (stat_byte),
  .ext_flags (ext_flags),
  .irq_n     (irq_n)
);

// File: tb/alm_irq_unit_tb_top.sv
module alm_irq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] cur_sec, cur_min, cur_hr, alm_sec, alm_min, alm_hr;
  logic       upd_done, per_tick, wake_evt, kick_evt, ramclr_evt;
  logic [2:0] ext_clr;
  logic       en_per, en_alm, en_upd, en_wake, en_kick, en_ramclr;
  logic       stat_rd;
  logic [7:0] stat_byte;
  logic [2:0] ext_flags;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alm_irq_unit dut_i (
    .clk(clk), .rst(rst),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .upd_done(upd_done), .per_tick(per_tick), .wake_evt(wake_evt),
    .kick_evt(kick_evt), .ramclr_evt(ramclr_evt), .ext_clr(ext_clr),
    .en_per(en_per), .en_alm(en_alm), .en_upd(en_upd),
    .en_wake(en_wake), .en_kick(en_kick), .en_ramclr(en_ramclr),
    .stat_rd(stat_rd), .stat_byte(stat_byte), .ext_flags(ext_flags),
    .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    upd_done = 0; per_tick = 0; wake_evt = 0; kick_evt = 0; ramclr_evt = 0;
    ext_clr = 3'b000; stat_rd = 0;
  endtask

  // apply strobes on one edge, then sample at the next falling edge
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic clear_all();
    @(negedge clk);
    stat_rd = 1; ext_clr = 3'b111;
    step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 status", stat_byte, 8'h00);
    chk("R1 ext", {5'b0, ext_flags}, 8'h00);
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_update();
    alm_hr = 8'h01; alm_min = 8'h02; alm_sec = 8'h03;
    cur_hr = 8'h10; cur_min = 8'h20; cur_sec = 8'h30;
    upd_done = 1;
    step();
    chk("R2 UF set", stat_byte, 8'h10);
    chk("R7 no enable no summary", {7'b0, irq_n}, 8'h01);
    stat_rd = 1;
    step();
    chk("R9 read clears", stat_byte, 8'h00);
  endtask

  task automatic t_alarm_exact();
    cur_hr = 8'h12; cur_min = 8'h34; cur_sec = 8'h56;
    alm_hr = 8'h12; alm_min = 8'h34; alm_sec = 8'h56;
    step();
    chk("R3 match without strobe", stat_byte, 8'h00);
    upd_done = 1;
    step();
    chk("R3 alarm on strobe", stat_byte, 8'h30);
    clear_all();
  endtask

  task automatic t_alarm_miss();
    alm_min = 8'h35;
    upd_done = 1;
    step();
    chk("R5 minute mismatch", stat_byte, 8'h10);
    clear_all();
    alm_min = 8'h34; alm_sec = 8'hBF; cur_sec = 8'h00;
    upd_done = 1;
    step();
    chk("R4 BF not wildcard", stat_byte, 8'h10);
    clear_all();
  endtask

  task automatic t_wild();
    alm_hr = 8'hC0; alm_min = 8'hFF; alm_sec = 8'h07;
    cur_hr = 8'h23; cur_min = 8'h59; cur_sec = 8'h07;
    upd_done = 1;
    step();
    chk("R4 wildcard hour and minute", stat_byte, 8'h30);
    clear_all();
  endtask

  task automatic t_periodic();
    per_tick = 1;
    step();
    chk("R6 PF set", stat_byte, 8'h40);
    clear_all();
  endtask

  task automatic t_summary();
    alm_hr = 8'hC0; alm_min = 8'hC0; alm_sec = 8'hC0;
    en_alm = 1; upd_done = 1;
    step();
    chk("R7 alarm enabled summary", stat_byte, 8'hB0);
    chk("R8 irq low", {7'b0, irq_n}, 8'h00);
    stat_rd = 1;
    step();
    chk("R8 irq released", {7'b0, irq_n}, 8'h01);
    en_alm = 0;
  endtask

  task automatic t_read_vs_set();
    stat_rd = 1; upd_done = 1;
    alm_sec = 8'h00; cur_sec = 8'h01;
    step();
    chk("R9 set wins over read", stat_byte, 8'h10);
    clear_all();
  endtask

  task automatic t_ext();
    wake_evt = 1;
    step();
    chk("R10 wake flag", {5'b0, ext_flags}, 8'h01);
    chk("R7 wake disabled", {7'b0, irq_n}, 8'h01);
    en_kick = 1; kick_evt = 1; upd_done = 1;
    step();
    chk("R10 kick flag", {5'b0, ext_flags}, 8'h03);
    chk("R7 kick summary", stat_byte, 8'h90);
    stat_rd = 1;
    step();
    chk("R11 summary held by kick", stat_byte, 8'h80);
    chk("R11 irq still low", {7'b0, irq_n}, 8'h00);
    ext_clr = 3'b010; kick_evt = 1;
    step();
    chk("R10 set wins over clear", {5'b0, ext_flags}, 8'h03);
    ext_clr = 3'b010;
    step();
    chk("R11 summary drops", stat_byte, 8'h00);
    chk("R11 irq released", {7'b0, irq_n}, 8'h01);
    ramclr_evt = 1;
    step();
    chk("R10 ramclr flag", {5'b0, ext_flags}, 8'h05);
    en_kick = 0;
    clear_all();
    chk("R10 ext cleared", {5'b0, ext_flags}, 8'h00);
  endtask

  task automatic t_enable_late();
    per_tick = 1;
    step();
    chk("R12 flag without enable", stat_byte, 8'h40);
    en_per = 1;
    step();
    chk("R12 enable takes effect", stat_byte, 8'hC0);
    en_per = 0;
    step();
    chk("R12 enable removed", stat_byte, 8'h40);
    clear_all();
  endtask

  initial begin
    rst = 1;
    idle_inputs();
    en_per = 0; en_alm = 0; en_upd = 0; en_wake = 0; en_kick = 0; en_ramclr = 0;
    cur_sec = 0; cur_min = 0; cur_hr = 0; alm_sec = 0; alm_min = 0; alm_hr = 0;
    t_reset();
    t_update();
    t_alarm_exact();
    t_alarm_miss();
    t_wild();
    t_periodic();
    t_summary();
    t_read_vs_set();
    t_ext();
    t_enable_late();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule